// File: doc/BRIEF.md
# Flash Command Interface Decoder

This block sits between a host bus and the internal program/erase engine of a flash macro. Every accepted bus write hands it a command byte (the low eight bits of the data word) together with an address. The block tracks sequences that span two bus cycles and chooses what a bus read returns: array data, identifier data or the status register. It starts erase, write, lock and one-time-programmable operations with a single-cycle pulse, and it suspends and resumes a running erase or write. It also keeps the status register that software polls.

A two-cycle erase or lock sequence needs a confirm byte. If the second byte is wrong, no operation starts and a sequence error is recorded. Error bits are sticky: only the clear-status command resets them, and that command is refused while an operation is suspended. Once an operation starts, reads are steered to the status register automatically. Ready/busy follows status bit 7.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset, read_mode is 0 (array), status is 80h, ready is 1, and op_start, op_suspend and op_resume are 0.
- R2: With no operation pending, FFh selects read_mode 0 (array), 90h selects 1 (identifier) and 70h selects 2 (status). A byte that is neither a mode command, 50h nor a setup code changes no output.
- R3: Two-cycle sequences start an operation on their second cycle: 20h then D0h is block erase (op_kind 1), 30h then D0h is chip erase (2), 60h then 01h sets a lock (4), 60h then D0h clears all locks (5), and 60h then F1h sets the permanent lock (6). The start is a one-cycle op_start pulse, with op_addr taken from the second cycle.
- R4: 40h or 10h followed by any cycle starts a word write (op_kind 3), and C0h followed by any cycle starts an OTP program (op_kind 7). op_addr and op_data carry the second cycle's address and data.
- R5: If the second byte after 20h, 30h or 60h is not a valid confirm, status bits 5 and 4 are set, read_mode becomes 2, and no op_start is issued.
- R6: When an operation starts, read_mode becomes 2 and status bit 7 and ready go to 0. An eng_done pulse while the operation runs sets bit 7 and ready back to 1.
- R7: At eng_done, eng_fail sets status bit 5 for block erase, chip erase and clear-locks, and bit 4 for every other kind. eng_vlow sets bit 3 and eng_prot sets bit 1.
- R8: Status bits 5, 4, 3 and 1 stay set until 50h is accepted with no operation pending. While an operation is suspended, 50h changes nothing.
- R9: While an operation runs, every byte other than B0h and 70h is ignored; in particular FFh leaves read_mode at 2.
- R10: B0h during a block erase or word write pulses op_suspend and sets status bit 7, plus bit 6 for an erase or bit 2 for a write. B0h during any other kind has no effect.
- R11: While suspended, FFh, 90h and 70h select read modes. D0h pulses op_resume, clears status bits 7, 6 and 2, and sets read_mode to 2.
- R12: If eng_done and B0h arrive in the same cycle, completion wins: no op_suspend, status bit 7 is 1, and bits 6 and 2 stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | One bus write cycle is present this clock |
| cmd_addr | input | AW | Address of the write cycle |
| cmd_data | input | DW | Data of the write cycle; bits 7:0 are the command byte |
| eng_done | input | 1 | Engine completion pulse |
| eng_fail | input | 1 | Engine reports an operation failure, qualified by eng_done |
| eng_vlow | input | 1 | Engine reports low programming voltage, qualified by eng_done |
| eng_prot | input | 1 | Engine reports a protected target, qualified by eng_done |
| read_mode | output | 2 | 0 array, 1 identifier, 2 status |
| status | output | 8 | Status register |
| ready | output | 1 | 1 when no operation is running |
| op_start | output | 1 | One-cycle start pulse to the engine |
| op_suspend | output | 1 | One-cycle suspend pulse to the engine |
| op_resume | output | 1 | One-cycle resume pulse to the engine |
| op_kind | output | 3 | Kind of the current or last operation |
| op_addr | output | AW | Address of the started operation |
| op_data | output | DW | Data of the started operation |

## Verification
Two functions can fall in the same cycle: engine completion and a host suspend request. The bench provokes this by raising eng_done and writing B0h in one clock during a block erase, which is the kind most exposed to suspension. It then checks that no suspend pulse appears, that ready returns, and that the suspend marker bits stay clear. It also confirms that the decoder accepts new commands afterwards. A second overlap is a command arriving while the engine runs: FFh is sent to a busy decoder, and the read mode is expected to stay at status.

// File: rtl/fcd_pkg.sv
package fcd_pkg;

  typedef enum logic [1:0] {
    RM_ARRAY  = 2'd0,
    RM_IDENT  = 2'd1,
    RM_STATUS = 2'd2
  } rmode_t;

  typedef enum logic [2:0] {
    OK_NONE       = 3'd0,
    OK_BLK_ERASE  = 3'd1,
    OK_CHIP_ERASE = 3'd2,
    OK_WRITE      = 3'd3,
    OK_LOCK_SET   = 3'd4,
    OK_LOCK_CLR   = 3'd5,
    OK_PERM_LOCK  = 3'd6,
    OK_OTP        = 3'd7
  } opkind_t;

  typedef enum logic [1:0] {
    SQ_READY = 2'd0,
    SQ_SETUP = 2'd1,
    SQ_RUN   = 2'd2,
    SQ_SUSP  = 2'd3
  } sqstate_t;

  localparam logic [7:0] C_READ_ARRAY = 8'hFF;
  localparam logic [7:0] C_READ_IDENT = 8'h90;
  localparam logic [7:0] C_READ_STAT  = 8'h70;
  localparam logic [7:0] C_CLEAR_STAT = 8'h50;
  localparam logic [7:0] C_BLK_SETUP  = 8'h20;
  localparam logic [7:0] C_CHIP_SETUP = 8'h30;
  localparam logic [7:0] C_WR_SETUP   = 8'h40;
  localparam logic [7:0] C_WR_SETUP2  = 8'h10;
  localparam logic [7:0] C_LOCK_SETUP = 8'h60;
  localparam logic [7:0] C_OTP_SETUP  = 8'hC0;
  localparam logic [7:0] C_CONFIRM    = 8'hD0;
  localparam logic [7:0] C_LOCK_ONE   = 8'h01;
  localparam logic [7:0] C_LOCK_PERM  = 8'hF1;
  localparam logic [7:0] C_SUSPEND    = 8'hB0;

  localparam logic [7:0] SR_RESET     = 8'h80;
  localparam logic [7:0] SR_CLEARABLE = 8'h3A;
  localparam logic [7:0] SR_SEQ_ERR   = 8'h30;
  localparam logic [7:0] SR_SUSP_ANY  = 8'h44;

  function automatic logic is_setup_code(input logic [7:0] b);
    return (b == C_BLK_SETUP) || (b == C_CHIP_SETUP) || (b == C_WR_SETUP) ||
           (b == C_WR_SETUP2) || (b == C_LOCK_SETUP) || (b == C_OTP_SETUP);
  endfunction

  function automatic rmode_t pick_mode(input logic [7:0] b, input rmode_t cur);
    if (b == C_READ_ARRAY) return RM_ARRAY;
    if (b == C_READ_IDENT) return RM_IDENT;
    if (b == C_READ_STAT)  return RM_STATUS;
    return cur;
  endfunction

  function automatic opkind_t second_cycle_kind(input logic [7:0] setup,
                                                input logic [7:0] conf);
    if (setup == C_WR_SETUP || setup == C_WR_SETUP2) return OK_WRITE;
    if (setup == C_OTP_SETUP) return OK_OTP;
    if (setup == C_BLK_SETUP  && conf == C_CONFIRM) return OK_BLK_ERASE;
    if (setup == C_CHIP_SETUP && conf == C_CONFIRM) return OK_CHIP_ERASE;
    if (setup == C_LOCK_SETUP) begin
      if (conf == C_LOCK_ONE)  return OK_LOCK_SET;
      if (conf == C_CONFIRM)   return OK_LOCK_CLR;
      if (conf == C_LOCK_PERM) return OK_PERM_LOCK;
    end
    return OK_NONE;
  endfunction

  function automatic logic can_suspend(input opkind_t k);
    return (k == OK_BLK_ERASE) || (k == OK_WRITE);
  endfunction

  function automatic logic [7:0] suspend_mark(input opkind_t k);
    return (k == OK_BLK_ERASE) ? 8'h40 : 8'h04;
  endfunction

  function automatic logic [7:0] done_error_bits(input opkind_t k, input logic fail,
                                                 input logic vlow, input logic prot);
    logic erase_like;
    erase_like = (k == OK_BLK_ERASE) || (k == OK_CHIP_ERASE) || (k == OK_LOCK_CLR);
    return {2'b00, fail & erase_like, fail & ~erase_like, vlow, 1'b0, prot, 1'b0};
  endfunction

endpackage

// File: rtl/fcd_seq.sv
module fcd_seq
  import fcd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [7:0] cmd_byte,
  input  logic       eng_done,
  output rmode_t     mode_q,
  output opkind_t    kind_q,
  output logic       ev_launch,
  output logic       ev_seq_err,
  output logic       ev_clear,
  output logic       ev_susp,
  output logic       ev_resume,
  output logic       ev_done,
  output logic       running,
  output logic       suspended
);

  sqstate_t   st_q, st_d;
  logic [7:0] pend_q, pend_d;
  rmode_t     mode_d;
  opkind_t    kind_d;
  opkind_t    conf_kind;

  assign conf_kind = second_cycle_kind(pend_q, cmd_byte);
  assign running   = (st_q == SQ_RUN);
  assign suspended = (st_q == SQ_SUSP);

  always_comb begin
    st_d       = st_q;
    pend_d     = pend_q;
    mode_d     = mode_q;
    kind_d     = kind_q;
    ev_launch  = 1'b0;
    ev_seq_err = 1'b0;
    ev_clear   = 1'b0;
    ev_susp    = 1'b0;
    ev_resume  = 1'b0;
    ev_done    = 1'b0;
    case (st_q)
      SQ_READY: begin
        if (cmd_valid) begin
          if (is_setup_code(cmd_byte)) begin
            st_d   = SQ_SETUP;
            pend_d = cmd_byte;
          end else begin
            mode_d   = pick_mode(cmd_byte, mode_q);
            ev_clear = (cmd_byte == C_CLEAR_STAT);
          end
        end
      end
      SQ_SETUP: begin
        if (cmd_valid) begin
          mode_d = RM_STATUS;
          if (conf_kind != OK_NONE) begin
            ev_launch = 1'b1;
            kind_d    = conf_kind;
            st_d      = SQ_RUN;
          end else begin
            ev_seq_err = 1'b1;
            st_d       = SQ_READY;
          end
        end
      end
      SQ_RUN: begin
        if (eng_done) begin
          ev_done = 1'b1;
          st_d    = SQ_READY;
        end else if (cmd_valid) begin
          if (cmd_byte == C_SUSPEND && can_suspend(kind_q)) begin
            ev_susp = 1'b1;
            st_d    = SQ_SUSP;
            mode_d  = RM_STATUS;
          end else if (cmd_byte == C_READ_STAT) begin
            mode_d = RM_STATUS;
          end
        end
      end
      SQ_SUSP: begin
        if (cmd_valid) begin
          if (cmd_byte == C_CONFIRM) begin
            ev_resume = 1'b1;
            st_d      = SQ_RUN;
            mode_d    = RM_STATUS;
          end else begin
            mode_d = pick_mode(cmd_byte, mode_q);
          end
        end
      end
      default: st_d = SQ_READY;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SQ_READY;
      pend_q <= 8'h00;
      mode_q <= RM_ARRAY;
      kind_q <= OK_NONE;
    end else begin
      st_q   <= st_d;
      pend_q <= pend_d;
      mode_q <= mode_d;
      kind_q <= kind_d;
    end
  end

endmodule

// File: rtl/fcd_status.sv
module fcd_status
  import fcd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ev_launch,
  input  logic       ev_done,
  input  logic       ev_seq_err,
  input  logic       ev_clear,
  input  logic       ev_susp,
  input  logic       ev_resume,
  input  opkind_t    kind,
  input  logic       eng_fail,
  input  logic       eng_vlow,
  input  logic       eng_prot,
  output logic [7:0] sr_q
);

  logic [7:0] sr_d;

  always_comb begin
    sr_d = sr_q;
    if (ev_launch) sr_d[7] = 1'b0;
    if (ev_done) begin
      sr_d[7] = 1'b1;
      sr_d    = sr_d | done_error_bits(kind, eng_fail, eng_vlow, eng_prot);
    end
    if (ev_seq_err) sr_d = sr_d | SR_SEQ_ERR;
    if (ev_clear)   sr_d = sr_d & ~SR_CLEARABLE;
    if (ev_susp) begin
      sr_d[7] = 1'b1;
      sr_d    = sr_d | suspend_mark(kind);
    end
    if (ev_resume) begin
      sr_d[7] = 1'b0;
      sr_d    = sr_d & ~SR_SUSP_ANY;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= SR_RESET;
    else        sr_q <= sr_d;
  end

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import fcd_pkg::*;
#(
  parameter int AW = 22,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic [AW-1:0] cmd_addr,
  input  logic [DW-1:0] cmd_data,
  input  logic          eng_done,
  input  logic          eng_fail,
  input  logic          eng_vlow,
  input  logic          eng_prot,
  output logic [1:0]    read_mode,
  output logic [7:0]    status,
  output logic          ready,
  output logic          op_start,
  output logic          op_suspend,
  output logic          op_resume,
  output logic [2:0]    op_kind,
  output logic [AW-1:0] op_addr,
  output logic [DW-1:0] op_data
);

  logic [7:0] cmd_byte;
  rmode_t     mode_q;
  opkind_t    kind_q;
  logic       ev_launch, ev_seq_err, ev_clear, ev_susp, ev_resume, ev_done;
  logic       running, suspended;

  assign cmd_byte = cmd_data[7:0];

  fcd_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .cmd_byte   (cmd_byte),
    .eng_done   (eng_done),
    .mode_q     (mode_q),
    .kind_q     (kind_q),
    .ev_launch  (ev_launch),
    .ev_seq_err (ev_seq_err),
    .ev_clear   (ev_clear),
    .ev_susp    (ev_susp),
    .ev_resume  (ev_resume),
    .ev_done    (ev_done),
    .running    (running),
    .suspended  (suspended)
  );

  fcd_status u_status (
    .clk        (clk),
    .rst_n      (rst_n),
    .ev_launch  (ev_launch),
    .ev_done    (ev_done),
    .ev_seq_err (ev_seq_err),
    .ev_clear   (ev_clear),
    .ev_susp    (ev_susp),
    .ev_resume  (ev_resume),
    .kind       (kind_q),
    .eng_fail   (eng_fail),
    .eng_vlow   (eng_vlow),
    .eng_prot   (eng_prot),
    .sr_q       (status)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_start   <= 1'b0;
      op_suspend <= 1'b0;
      op_resume  <= 1'b0;
      op_addr    <= '0;
      op_data    <= '0;
    end else begin
      op_start   <= ev_launch;
      op_suspend <= ev_susp;
      op_resume  <= ev_resume;
      if (ev_launch) begin
        op_addr <= cmd_addr;
        op_data <= cmd_data;
      end
    end
  end

  assign read_mode = mode_q;
  assign op_kind   = kind_q;
  assign ready     = status[7];

endmodule

// File: rtl/fcd_checker.sv
module fcd_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_valid,
  input logic [7:0] cmd_byte,
  input logic       eng_done,
  input logic       running,
  input logic       suspended,
  input logic       ev_seq_err,
  input logic       ev_clear,
  input logic [1:0] read_mode,
  input logic [7:0] status,
  input logic       ready,
  input logic       op_start,
  input logic       op_suspend,
  input logic       op_resume
);

  AST_PULSES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({op_start, op_suspend, op_resume})); // R3

  AST_LAUNCH_SHOWS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    op_start |-> (read_mode == 2'd2) && !ready); // R6

  AST_RUN_MEANS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> !status[7]); // R6

  AST_SEQ_ERR_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_seq_err |=> status[5] && status[4]); // R5

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    status[5] && !ev_clear |=> status[5]); // R8

  AST_SUSP_CLEAR_NOP: assert property (@(posedge clk) disable iff (!rst_n)
    suspended && cmd_valid && (cmd_byte == 8'h50) |=> $stable(status)); // R8

  AST_BUSY_IGNORES_ARRAY: assert property (@(posedge clk) disable iff (!rst_n)
    running && cmd_valid && (cmd_byte == 8'hFF) |=> $stable(read_mode)); // R9

  AST_SUSP_MARKED: assert property (@(posedge clk) disable iff (!rst_n)
    suspended |-> status[7] && (status[6] || status[2])); // R10

  AST_DONE_BEATS_SUSPEND: assert property (@(posedge clk) disable iff (!rst_n)
    running && eng_done |=> !op_suspend && status[7] && !status[6]); // R12

endmodule

bind flash_cmd_decoder fcd_checker u_fcd_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmd_valid  (cmd_valid),
  .cmd_byte   (cmd_byte),
  .eng_done   (eng_done),
  .running    (running),
  .suspended  (suspended),
  .ev_seq_err (ev_seq_err),
  .ev_clear   (ev_clear),
  .read_mode  (read_mode),
  .status     (status),
  .ready      (ready),
  .op_start   (op_start),
  .op_suspend (op_suspend),
  .op_resume  (op_resume)
);

// File: tb/tb_flash_cmd_decoder.sv
`timescale 1ns/1ps
module tb_flash_cmd_decoder;
  localparam int AW = 12;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic [AW-1:0] cmd_addr = '0;
  logic [DW-1:0] cmd_data = '0;
  logic          eng_done = 1'b0, eng_fail = 1'b0, eng_vlow = 1'b0, eng_prot = 1'b0;
  logic [1:0]    read_mode;
  logic [7:0]    status;
  logic          ready, op_start, op_suspend, op_resume;
  logic [2:0]    op_kind;
  logic [AW-1:0] op_addr;
  logic [DW-1:0] op_data;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  flash_cmd_decoder #(.AW(AW), .DW(DW)) dut (.*);

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic [DW-1:0] d, input logic [AW-1:0] a,
                      input logic dn, input logic f, input logic vl, input logic p);
    @(negedge clk);
    cmd_valid = v; cmd_data = d; cmd_addr = a;
    eng_done = dn; eng_fail = f; eng_vlow = vl; eng_prot = p;
    @(negedge clk);
    cmd_valid = 1'b0; eng_done = 1'b0; eng_fail = 1'b0; eng_vlow = 1'b0; eng_prot = 1'b0;
  endtask

  task automatic cmd(input logic [7:0] b);
    step(1'b1, {8'h00, b}, '0, 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic done(input logic f, input logic vl, input logic p);
    step(1'b0, '0, '0, 1'b1, f, vl, p);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  function automatic int single_mode(input int b);
    case (b)
      'hFF: return 0;
      'h90: return 1;
      'h70: return 2;
      default: return 0;
    endcase
  endfunction

  function automatic int expect_kind(input int setup, input int b);
    if (setup == 'h20) return (b == 'hD0) ? 1 : 0;
    if (setup == 'h30) return (b == 'hD0) ? 2 : 0;
    if (b == 'h01) return 4;
    if (b == 'hD0) return 5;
    if (b == 'hF1) return 6;
    return 0;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int setups[3] = '{'h20, 'h30, 'h60};
    do_reset();
    chk("R1 mode", read_mode, 0);
    chk("R1 status", status, 'h80);
    chk("R1 ready", ready, 1);
    chk("R1 pulses", {op_start, op_suspend, op_resume}, 0);

    // R2: every single byte from reset
    for (int b = 0; b < 256; b++) begin
      do_reset();
      cmd(8'(b));
      chk($sformatf("R2 mode byte %0h", b), read_mode, single_mode(b));
      chk($sformatf("R2 status byte %0h", b), status, 'h80);
      chk("R2 no start", op_start, 0);
    end
    do_reset();
    cmd(8'h70); cmd(8'h55);
    chk("R2 unlisted keeps status mode", read_mode, 2);

    // R3 and R5: every second byte after each two-cycle setup
    for (int s = 0; s < 3; s++) begin
      for (int b = 0; b < 256; b++) begin
        int k;
        k = expect_kind(setups[s], b);
        do_reset();
        cmd(8'(setups[s]));
        step(1'b1, 16'(b), 12'(12'h300 + b), 1'b0, 1'b0, 1'b0, 1'b0);
        chk("R5 mode after second cycle", read_mode, 2);
        if (k != 0) begin
          chk("R3 start", op_start, 1);
          chk("R3 kind", op_kind, k);
          chk("R3 addr", op_addr, 'h300 + b);
          chk("R6 status busy", status, 'h00);
        end else begin
          chk("R5 no start", op_start, 0);
          chk("R5 seq error bits", status, 'hB0);
        end
      end
    end

    // R4, R6, R7, R8, R9
    do_reset();
    cmd(8'h40);
    step(1'b1, 16'hBEEF, 12'h456, 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R4 start", op_start, 1);
    chk("R4 kind", op_kind, 3);
    chk("R4 addr", op_addr, 'h456);
    chk("R4 data", op_data, 'hBEEF);
    chk("R6 ready low", ready, 0);
    cmd(8'hFF);
    chk("R9 array ignored while busy", read_mode, 2);
    cmd(8'h90);
    chk("R9 ident ignored while busy", read_mode, 2);
    done(1'b1, 1'b0, 1'b0);
    chk("R7 write fail sets bit4", status, 'h90);
    chk("R6 ready back", ready, 1);
    cmd(8'hFF);
    chk("R8 sticky after mode change", status, 'h90);
    chk("R2 array selected", read_mode, 0);
    cmd(8'h10);
    step(1'b1, 16'h1234, 12'h0AB, 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R4 alternate write setup", op_kind, 3);
    done(1'b0, 1'b0, 1'b0);
    cmd(8'hC0);
    step(1'b1, 16'h00FD, 12'h080, 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R4 otp kind", op_kind, 7);
    chk("R4 otp data", op_data, 'h00FD);
    chk("R6 errors kept on launch", status, 'h10);
    done(1'b0, 1'b1, 1'b1);
    chk("R7 vlow and prot", status, 'h9A);
    cmd(8'h50);
    chk("R8 clear", status, 'h80);

    // R7 error bit per kind
    cmd(8'h30); cmd(8'hD0); done(1'b1, 1'b0, 1'b0);
    chk("R7 chip erase fail bit5", status, 'hA0);
    cmd(8'h50);
    cmd(8'h60); cmd(8'hD0); done(1'b1, 1'b0, 1'b0);
    chk("R7 clear locks fail bit5", status, 'hA0);
    cmd(8'h50);
    cmd(8'h60); cmd(8'h01); done(1'b1, 1'b0, 1'b0);
    chk("R7 set lock fail bit4", status, 'h90);
    cmd(8'h50);

    // R10, R11, R8 on a suspended write
    cmd(8'h40);
    step(1'b1, 16'h0F0F, 12'h010, 1'b0, 1'b0, 1'b0, 1'b0);
    cmd(8'hB0);
    chk("R10 suspend pulse", op_suspend, 1);
    chk("R10 write suspend status", status, 'h84);
    chk("R10 ready", ready, 1);
    step(1'b1, 16'h0050, '0, 1'b0, 1'b1, 1'b1, 1'b1);
    chk("R8 clear refused while suspended", status, 'h84);
    cmd(8'hFF);
    chk("R11 array while suspended", read_mode, 0);
    cmd(8'h90);
    chk("R11 ident while suspended", read_mode, 1);
    cmd(8'hD0);
    chk("R11 resume pulse", op_resume, 1);
    chk("R11 status after resume", status, 'h00);
    chk("R11 mode after resume", read_mode, 2);
    done(1'b0, 1'b0, 1'b0);
    chk("R6 done after resume", status, 'h80);

    cmd(8'h20); cmd(8'hD0); cmd(8'hB0);
    chk("R10 erase suspend status", status, 'hC0);
    cmd(8'hD0);
    chk("R11 erase resume", status, 'h00);
    done(1'b0, 1'b0, 1'b0);

    cmd(8'h30); cmd(8'hD0); cmd(8'hB0);
    chk("R10 chip erase not suspendable", op_suspend, 0);
    chk("R10 chip erase still busy", status, 'h00);
    done(1'b0, 1'b0, 1'b0);

    // R12: completion and suspend in the same cycle
    cmd(8'h20); cmd(8'hD0);
    step(1'b1, 16'h00B0, '0, 1'b1, 1'b0, 1'b0, 1'b0);
    chk("R12 no suspend pulse", op_suspend, 0);
    chk("R12 status done", status, 'h80);
    chk("R12 ready", ready, 1);
    cmd(8'hFF);
    chk("R12 idle afterwards", read_mode, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule